// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status flags of an asynchronous serial port. The transmitter and receiver cores report events to it as single-cycle strobes: a character moved from the transmit holding register into the shift register, the last bit of a character sent, a reception finished (with its stop-bit sample, received parity bit and received multiprocessor bit), the transmit data register written and the receive data register read. The block turns these strobes into flags. It also checks the parity of each received character against the configured even or odd mode.

Software reaches the flags over a register bus. The five event flags in the upper bits are sticky. Software can only clear them, and only with a two-step sequence: first read the flag while it is 1, then write 0 to it. A 0 written without that earlier read does nothing. Writing 1 to these bits never has an effect. Hardware events can also clear some flags. When a set event and a clear meet in the same cycle, the set wins. Every flag change becomes visible on `stat` on the clock edge after the cause.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset, `stat` equals 8'h84. Bit 7 (transmit-empty) and bit 2 (transmit-end) are 1, and all other bits are 0.
- R2: A bus write with a 0 in bit 7, 6, 5, 4 or 3 clears that flag only if the flag is armed. A bus write with a 1 in any of these bits leaves the flag unchanged.
- R3: A bus read arms each of bits 7..3 that it returns as 1. A clearing write consumes the arm. The arm is also dropped once the flag is 0. A second write of 0 without a new read has no effect.
- R4: If a hardware set event for a flag falls in the same cycle as a clear of that flag, the flag is 1 afterwards.
- R5: Bit 7 is set by `tx_load` or while `tx_en` is 0. It is cleared by `tdr_wr` or by an armed software clear.
- R6: Bit 2 is set by `tx_last` while bit 7 is 1, or while `tx_en` is 0. It is cleared by `tdr_wr` or by an armed software clear of bit 7. Bus writes to bit 2 have no effect.
- R7: Bit 6 (receive-full) is set by `rx_done` when all three hold: `rx_stop` is 1, there is no parity error, and bit 6 was 0. It is cleared by `rdr_rd` or by an armed software clear.
- R8: Bit 5 (overrun) is set by `rx_done` while bit 6 is 1.
- R9: Bit 4 (framing error) is set by `rx_done` with `rx_stop` equal to 0.
- R10: Bit 3 (parity error) is set by `rx_done` when `par_en` is 1 and the count of ones in `rx_data` plus `rx_par` is odd while `par_odd` is 0, or even while `par_odd` is 1.
- R11: Bit 1 takes `rx_mpb` on every `rx_done` and ignores bus writes. Bit 0 takes `bus_wdata[0]` on every bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Status register read strobe |
| bus_wr | input | 1 | Status register write strobe |
| bus_wdata | input | 8 | Write data |
| tdr_wr | input | 1 | Transmit data register was written |
| rdr_rd | input | 1 | Receive data register was read |
| tx_en | input | 1 | Transmitter enable control bit |
| tx_load | input | 1 | Holding register moved into the transmit shifter |
| tx_last | input | 1 | Last bit of a character sent |
| rx_done | input | 1 | Reception complete |
| rx_stop | input | 1 | Sampled stop bit, valid with rx_done |
| rx_data | input | DATA_W | Received character, valid with rx_done |
| rx_par | input | 1 | Received parity bit |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_mpb | input | 1 | Received multiprocessor bit |
| stat | output | 8 | Status flags, also the bus read data |

## Verification
The bench drives each corner case directly, then runs a long random phase against its own reference model, comparing the flags every clock.

Unarmed writes of 0 and writes of 1 must leave the flags alone. A design without the arm would clear on any 0. A design with a wrong arm polarity would clear on 1s.

A second 0 written without a new read must do nothing. A design whose arm survives the clear would clear twice from one read.

A set event that lands on the same cycle as a clear must leave the flag at 1. A design with the priority reversed would drop an error that just happened.

Receptions are sent both while receive-full is still set and with bad stop or parity bits. A design that sets receive-full on a failed reception, or misses an overrun, shows it at once. The bench also checks that transmit-end is set only while transmit-empty is 1, and that it falls along with a software clear of transmit-empty.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int STAT_W    = 8;
    localparam int STICKY_N  = 5;
    localparam int STICKY_LO = STAT_W - STICKY_N;
    localparam logic [STAT_W-1:0] STAT_RST = 8'h84;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic overrun;
        logic frame_err;
        logic par_err;
        logic tx_end;
        logic mp_rx;
        logic mp_tx;
    } stat_t;
endpackage

// File: rtl/uart_stat_evt.sv
module uart_stat_evt #(
    parameter int DATA_W = 8
) (
    input  logic              tx_en,
    input  logic              tx_load,
    input  logic              tx_last,
    input  logic              tdr_wr,
    input  logic              rdr_rd,
    input  logic              rx_done,
    input  logic              rx_stop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tx_empty_q,
    input  logic              rx_full_q,
    output logic [4:0]        sticky_set,
    output logic [4:0]        sticky_hwclr,
    output logic              tend_set,
    output logic              tend_hwclr
);
    // index 4 tx_empty, 3 rx_full, 2 overrun, 1 frame_err, 0 par_err
    logic par_bad;

    always_comb begin
        par_bad = par_en & (^{rx_data, rx_par, par_odd});

        sticky_set[4] = tx_load | ~tx_en;
        sticky_set[3] = rx_done & rx_stop & ~par_bad & ~rx_full_q;
        sticky_set[2] = rx_done & rx_full_q;
        sticky_set[1] = rx_done & ~rx_stop;
        sticky_set[0] = rx_done & par_bad;

        sticky_hwclr[4] = tdr_wr;
        sticky_hwclr[3] = rdr_rd;
        sticky_hwclr[2] = 1'b0;
        sticky_hwclr[1] = 1'b0;
        sticky_hwclr[0] = 1'b0;

        tend_set   = ~tx_en | (tx_last & tx_empty_q);
        tend_hwclr = tdr_wr;
    end
endmodule

// File: rtl/stat_flag_cell.sv
module stat_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic hw_clr,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic q,
    output logic armed,
    output logic sw_clr
);
    typedef struct packed {
        logic flag;
        logic arm;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        sw_clr = wr & ~wbit & cell_q.arm;
        if (set_ev)
            cell_d.flag = 1'b1;
        else if (hw_clr || sw_clr)
            cell_d.flag = 1'b0;
        if (rd)
            cell_d.arm = cell_q.flag;
        else if (sw_clr)
            cell_d.arm = 1'b0;
        else
            cell_d.arm = cell_q.arm & cell_q.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q.flag <= RST_VAL;
            cell_q.arm  <= 1'b0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign q     = cell_q.flag;
    assign armed = cell_q.arm;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> q); // R4
    AST_CLR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !set_ev && !hw_clr && wr && wbit) |=> q); // R2
    AST_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !rd) |=> !armed); // R3
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              tdr_wr,
    input  logic              rdr_rd,
    input  logic              tx_en,
    input  logic              tx_load,
    input  logic              tx_last,
    input  logic              rx_done,
    input  logic              rx_stop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_mpb,
    output logic [7:0]        stat
);
    import uart_stat_pkg::*;

    typedef struct packed {
        logic tx_end;
        logic mp_rx;
        logic mp_tx;
    } low_t;

    low_t low_d, low_q;
    logic [STICKY_N-1:0] s_set, s_hwclr, s_q, s_arm, s_swclr;
    logic tend_set, tend_hwclr;
    stat_t view;

    uart_stat_evt #(.DATA_W(DATA_W)) u_evt (
        .tx_en(tx_en), .tx_load(tx_load), .tx_last(tx_last),
        .tdr_wr(tdr_wr), .rdr_rd(rdr_rd), .rx_done(rx_done),
        .rx_stop(rx_stop), .rx_data(rx_data), .rx_par(rx_par),
        .par_en(par_en), .par_odd(par_odd),
        .tx_empty_q(s_q[4]), .rx_full_q(s_q[3]),
        .sticky_set(s_set), .sticky_hwclr(s_hwclr),
        .tend_set(tend_set), .tend_hwclr(tend_hwclr)
    );

    for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
        stat_flag_cell #(.RST_VAL(STAT_RST[STICKY_LO+i])) u_cell (
            .clk(clk), .rst_n(rst_n),
            .set_ev(s_set[i]), .hw_clr(s_hwclr[i]),
            .rd(bus_rd), .wr(bus_wr), .wbit(bus_wdata[STICKY_LO+i]),
            .q(s_q[i]), .armed(s_arm[i]), .sw_clr(s_swclr[i])
        );
    end

    always_comb begin
        low_d = low_q;
        if (tend_set)
            low_d.tx_end = 1'b1;
        else if (tend_hwclr || s_swclr[4])
            low_d.tx_end = 1'b0;
        if (rx_done)
            low_d.mp_rx = rx_mpb;
        if (bus_wr)
            low_d.mp_tx = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_q <= low_t'(STAT_RST[2:0]);
        else
            low_q <= low_d;
    end

    always_comb begin
        view = stat_t'({s_q, low_q});
        stat = view;
    end

    AST_TEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last && view.tx_empty) |=> view.tx_end); // R6
    AST_TEND_BUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (!view.tx_end && tx_en && !tx_last) |=> !view.tx_end); // R6
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(view.overrun) |-> $past(view.rx_full)); // R8
    AST_MPR_RO: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(view.mp_rx)); // R11
    AST_FULL_ARMED_WHEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && view.rx_full) |=> (s_arm[3] || !view.rx_full)); // R3
endmodule

// File: tb/sim_uart_stat_reg.sv
module sim_uart_stat_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rd, bus_wr, tdr_wr, rdr_rd, tx_en, tx_load, tx_last;
    logic rx_done, rx_stop, rx_par, par_en, par_odd, rx_mpb;
    logic [7:0] bus_wdata, rx_data, stat;

    int checks = 0;
    int errors = 0;
    bit [7:0] m;
    bit [7:0] arm;

    always #5 clk = ~clk;

    uart_stat_reg #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .tdr_wr(tdr_wr), .rdr_rd(rdr_rd),
        .tx_en(tx_en), .tx_load(tx_load), .tx_last(tx_last),
        .rx_done(rx_done), .rx_stop(rx_stop), .rx_data(rx_data),
        .rx_par(rx_par), .par_en(par_en), .par_odd(par_odd),
        .rx_mpb(rx_mpb), .stat(stat)
    );

    function automatic string tag_of(int b);
        case (b)
            7: return "R5";
            6: return "R7";
            5: return "R8";
            4: return "R9";
            3: return "R10";
            2: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic idle();
        bus_rd = 0; bus_wr = 0; bus_wdata = 8'h00; tdr_wr = 0; rdr_rd = 0;
        tx_en = 1; tx_load = 0; tx_last = 0; rx_done = 0; rx_stop = 1;
        rx_data = 8'h00; rx_par = 0; par_en = 0; par_odd = 0; rx_mpb = 0;
    endtask

    task automatic model_step();
        bit [7:0] n;
        bit [7:0] swc;
        bit perr;
        int ones;
        n = m;
        swc = 8'h00;
        for (int b = 3; b < 8; b++)
            if (bus_wr && !bus_wdata[b] && arm[b]) swc[b] = 1;
        ones = $countones(rx_data) + (rx_par ? 1 : 0);
        perr = rx_done && par_en && ((ones % 2) != (par_odd ? 1 : 0));
        if (tx_load || !tx_en) n[7] = 1; else if (tdr_wr || swc[7]) n[7] = 0;
        if (rx_done && rx_stop && !perr && !m[6]) n[6] = 1;
        else if (rdr_rd || swc[6]) n[6] = 0;
        if (rx_done && m[6]) n[5] = 1; else if (swc[5]) n[5] = 0;
        if (rx_done && !rx_stop) n[4] = 1; else if (swc[4]) n[4] = 0;
        if (perr) n[3] = 1; else if (swc[3]) n[3] = 0;
        if (!tx_en || (tx_last && m[7])) n[2] = 1;
        else if (tdr_wr || swc[7]) n[2] = 0;
        if (rx_done) n[1] = rx_mpb;
        if (bus_wr) n[0] = bus_wdata[0];
        for (int b = 3; b < 8; b++) begin
            if (bus_rd) arm[b] = m[b];
            else if (swc[b]) arm[b] = 0;
            else arm[b] = arm[b] & m[b];
        end
        m = n;
    endtask

    task automatic compare_model();
        checks++;
        if (stat !== m) begin
            errors++;
            for (int b = 0; b < 8; b++)
                if (stat[b] !== m[b])
                    $display("FAIL %s bit %0d: actual %b expected %b (stat %h model %h)",
                             tag_of(b), b, stat[b], m[b], stat, m);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
        idle();
    endtask

    task automatic expect_bit(string tag, int b, bit v);
        checks++;
        if (stat[b] !== v) begin
            errors++;
            $display("FAIL %s bit %0d: actual %b expected %b", tag, b, stat[b], v);
        end
    endtask

    initial begin
        idle();
        m = 8'h84;
        arm = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        checks++;
        if (stat !== 8'h84) begin
            errors++;
            $display("FAIL R1: actual %h expected %h", stat, 8'h84);
        end
        // R2: unarmed write of zero is ignored
        bus_wr = 1; bus_wdata = 8'h00; step();
        expect_bit("R2", 7, 1);
        // R3: read then write zero clears; R6 tx_end follows
        bus_rd = 1; step();
        bus_wr = 1; bus_wdata = 8'h00; step();
        expect_bit("R3", 7, 0);
        expect_bit("R6", 2, 0);
        tx_load = 1; step();
        expect_bit("R5", 7, 1);
        bus_wr = 1; bus_wdata = 8'h00; step();
        expect_bit("R3", 7, 1);
        tx_last = 1; step();
        expect_bit("R6", 2, 1);
        tdr_wr = 1; step();
        expect_bit("R5", 7, 0);
        expect_bit("R6", 2, 0);
        rx_done = 1; rx_stop = 1; rx_data = 8'h03; par_en = 1; step();
        expect_bit("R7", 6, 1);
        expect_bit("R10", 3, 0);
        rx_done = 1; rx_stop = 1; rx_data = 8'h03; par_en = 1; step();
        expect_bit("R8", 5, 1);
        rx_done = 1; rx_stop = 0; step();
        expect_bit("R9", 4, 1);
        rx_done = 1; rx_data = 8'h01; par_en = 1; step();
        expect_bit("R10", 3, 1);
        rx_done = 1; rx_data = 8'h01; rx_par = 1; par_en = 1; par_odd = 1; step();
        expect_bit("R10", 3, 1);
        rdr_rd = 1; step();
        expect_bit("R7", 6, 0);
        bus_rd = 1; step();
        bus_wr = 1; bus_wdata = 8'hFF; step();
        expect_bit("R2", 5, 1);
        expect_bit("R11", 0, 1);
        bus_rd = 1; step();
        bus_wr = 1; bus_wdata = 8'h00; rx_done = 1; rx_stop = 0; step();
        expect_bit("R4", 4, 1);
        expect_bit("R2", 5, 0);
        rx_done = 1; rx_mpb = 1; step();
        expect_bit("R11", 1, 1);
        bus_wr = 1; bus_wdata = 8'h00; step();
        expect_bit("R11", 1, 1);
        tx_en = 0; step();
        expect_bit("R5", 7, 1);
        expect_bit("R6", 2, 1);

        for (int k = 0; k < 4000; k++) begin
            bus_rd    = ($urandom_range(0, 9) < 3);
            bus_wr    = ($urandom_range(0, 9) < 2);
            bus_wdata = 8'($urandom);
            tdr_wr    = ($urandom_range(0, 9) == 0);
            rdr_rd    = ($urandom_range(0, 9) == 0);
            tx_en     = ($urandom_range(0, 19) != 0);
            tx_load   = ($urandom_range(0, 9) == 0);
            tx_last   = ($urandom_range(0, 9) == 0);
            rx_done   = ($urandom_range(0, 5) == 0);
            rx_stop   = ($urandom_range(0, 7) != 0);
            rx_data   = 8'($urandom);
            rx_par    = 1'($urandom);
            par_en    = 1'($urandom);
            par_odd   = 1'($urandom);
            rx_mpb    = 1'($urandom);
            step();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule